// File: doc/BRIEF.md
# Dual-Section Decade Counter

This block is a fully synchronous model of a split decade counter. It holds two counting sections that share one clock: a single-bit toggle section and a three-bit section that steps through five states (0 to 4). Each section advances only in cycles where its own step input is high. These step inputs take the place of separate counting clocks, so the whole block stays on one clock domain.

Used alone, the toggle section divides by two and the three-bit section divides by five. Driving the three-bit section from the toggle section gives a BCD decade counter that runs 0 to 9 and wraps. The two sections can be joined outside the block, by driving the upper step input from the user's own logic. They can also be joined inside it with a chain-select input, which is the path used for testing.

Two gated control pairs override counting. When both inputs of the clear pair are high, the next edge loads zero. When both inputs of the nine pair are high, the next edge loads nine. The nine pair wins over the clear pair. A single input of either pair on its own does nothing.

Top module: `dsdc_counter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `cnt_q` becomes 4'b0000 after that edge.
- R2: With neither control pair fully active, `cnt_q[0]` inverts at every edge where `step_lo` is 1 and holds at every edge where `step_lo` is 0.
- R3: With `chain_en` at 0 and neither control pair fully active, `cnt_q[3:1]` advances in the order 0,1,2,3,4,0 at each edge where `step_hi` is 1. It holds when `step_hi` is 0, whatever `step_lo` does.
- R4: With `chain_en` at 1, `step_hi` is ignored. `cnt_q[3:1]` advances exactly at the edges where `step_lo` is 1 and `cnt_q[0]` is 1 (the toggle bit falling). As a result, `cnt_q` read as a binary number counts 0 through 9 and returns to 0.
- R5: When `clr_a` and `clr_b` are both 1 at an edge and the nine pair is not fully active, `cnt_q` becomes 0 after that edge, regardless of the step inputs.
- R6: `clr_a` or `clr_b` alone at 1 leaves counting exactly as if both were 0.
- R7: When `nine_a` and `nine_b` are both 1 at an edge, `cnt_q` becomes 4'b1001 after that edge, regardless of the step inputs.
- R8: `nine_a` or `nine_b` alone at 1 leaves counting exactly as if both were 0.
- R9: When both pairs are fully active at the same edge, `cnt_q` becomes 4'b1001, not 0.
- R10: From reset, clear or preset onward, `cnt_q[3:1]` never exceeds 4, so `cnt_q` never exceeds 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_lo | input | 1 | Advance enable for the toggle section |
| step_hi | input | 1 | Advance enable for the five-state section (used when `chain_en` is 0) |
| chain_en | input | 1 | 1 joins the sections internally as a decade counter |
| clr_a | input | 1 | Clear pair, first input |
| clr_b | input | 1 | Clear pair, second input |
| nine_a | input | 1 | Preset-to-nine pair, first input |
| nine_b | input | 1 | Preset-to-nine pair, second input |
| cnt_q | output | 4 | Count; bit 0 is the toggle section, bits 3:1 the five-state section |

## Verification
All of the block's state appears directly on `cnt_q`, so a wrong internal value shows at the port one clock after the edge that produced it. A bad carry from the toggle section to the five-state section shows up in decade mode as a skipped or repeated BCD value on the very next edge. A bad wrap shows as a code above 9, or as a return to zero early. A wrong control-pair decode shows on the first edge where only one input of a pair is high, or where both pairs are high together. For these reasons the bench compares the full count against its own model on every edge.

// File: rtl/dsdc_pkg.sv
// Package: shared types and helpers for the dual-section decade counter.
// Assumes: a section value that reaches its last state wraps to zero.
package dsdc_pkg;

    // Decoded override requests, ordered by priority (preset first).
    typedef struct packed {
        logic preset;
        logic clear;
    } dsdc_ovr_t;

    // Index of each gated control pair in the pair array.
    localparam int unsigned PAIR_PRESET = 0;
    localparam int unsigned PAIR_CLEAR  = 1;
    localparam int unsigned NUM_PAIRS   = 2;

endpackage

// File: rtl/dsdc_gate_pair.sv
// Module: dsdc_gate_pair
// What: AND of N control inputs. The request is raised only when every
//       input of the group is high.
// Assumes: inputs are synchronous to the counter clock.
module dsdc_gate_pair #(
    parameter int unsigned N = 2
) (
    input  logic [N-1:0] req_in,
    output logic         req_out
);

    // Request fires only when all inputs agree.
    always_comb begin
        req_out = &req_in;
    end

endmodule

// File: rtl/dsdc_toggle_stage.sv
// Module: dsdc_toggle_stage
// What: one-bit divide-by-two section. It inverts on each enabled edge,
//       and can be forced to 1 (preset) or 0 (clear).
//       It also flags the enabled edge that takes the bit from 1 to 0.
// Assumes: preset has priority over clear, and both override stepping.
module dsdc_toggle_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic load_one,
    input  logic load_zero,
    input  logic step,
    output logic bit_q,
    output logic fall_en
);

    // State update: reset, overrides, then toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q <= 1'b0;
        end else if (load_one) begin
            bit_q <= 1'b1;
        end else if (load_zero) begin
            bit_q <= 1'b0;
        end else if (step) begin
            bit_q <= ~bit_q;
        end
    end

    // One-cycle enable: the coming edge drops the bit from 1 to 0.
    always_comb begin
        fall_en = step & bit_q & ~load_one & ~load_zero;
    end

endmodule

// File: rtl/dsdc_modn_stage.sv
// Module: dsdc_modn_stage
// What: W-bit section that counts 0 to MOD-1 on enabled edges and wraps.
//       It can be forced to MOD-1 (preset) or to 0 (clear).
// Assumes: MOD fits in W bits and MOD >= 2. Values at or above MOD-1
//          wrap to 0, so the section can never climb out of range.
module dsdc_modn_stage #(
    parameter int unsigned W   = 3,
    parameter int unsigned MOD = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_top,
    input  logic         load_zero,
    input  logic         step,
    output logic [W-1:0] val_q
);

    localparam logic [W-1:0] TOP_VAL = W'(MOD - 1);

    logic [W-1:0] val_inc;

    // Next value when stepping, with wrap at the top state.
    always_comb begin
        if (val_q >= TOP_VAL) begin
            val_inc = '0;
        end else begin
            val_inc = val_q + W'(1);
        end
    end

    // State update: reset, overrides, then advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
        end else if (load_top) begin
            val_q <= TOP_VAL;
        end else if (load_zero) begin
            val_q <= '0;
        end else if (step) begin
            val_q <= val_inc;
        end
    end

endmodule

// File: rtl/dsdc_counter.sv
// Module: dsdc_counter (top)
// What: split decade counter. A toggle section (bit 0) and a five-state
//       section (bits 3:1), each with its own step enable. Two gated
//       control pairs give preset-to-nine (winning) and clear-to-zero.
//       chain_en joins the sections inside the block to form a BCD counter.
// Assumes: one clock domain, synchronous active-low reset, all inputs
//          synchronous.
module dsdc_counter #(
    parameter int unsigned HI_W   = 3,
    parameter int unsigned HI_MOD = 5,
    parameter int unsigned PAIR_N = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step_lo,
    input  logic            step_hi,
    input  logic            chain_en,
    input  logic            clr_a,
    input  logic            clr_b,
    input  logic            nine_a,
    input  logic            nine_b,
    output logic [HI_W:0]   cnt_q
);
    import dsdc_pkg::*;

    localparam int unsigned CNT_W = HI_W + 1;

    logic [PAIR_N-1:0] pair_in [NUM_PAIRS];
    logic [NUM_PAIRS-1:0] pair_hit;
    dsdc_ovr_t ovr;
    logic lo_bit;
    logic lo_fall;
    logic hi_step;
    logic [HI_W-1:0] hi_val;

    // Gather the raw control pairs into the pair array.
    always_comb begin
        pair_in[PAIR_PRESET] = {nine_b, nine_a};
        pair_in[PAIR_CLEAR]  = {clr_b, clr_a};
    end

    // One gate per control pair.
    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
        dsdc_gate_pair #(.N(PAIR_N)) gate_i (
            .req_in  (pair_in[g]),
            .req_out (pair_hit[g])
        );
    end

    // Priority: preset beats clear.
    always_comb begin
        ovr.preset = pair_hit[PAIR_PRESET];
        ovr.clear  = pair_hit[PAIR_CLEAR] & ~pair_hit[PAIR_PRESET];
    end

    dsdc_toggle_stage lo_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_one  (ovr.preset),
        .load_zero (ovr.clear),
        .step      (step_lo),
        .bit_q     (lo_bit),
        .fall_en   (lo_fall)
    );

    // Upper section step source: internal carry or its own enable.
    always_comb begin
        hi_step = chain_en ? lo_fall : step_hi;
    end

    dsdc_modn_stage #(.W(HI_W), .MOD(HI_MOD)) hi_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_top  (ovr.preset),
        .load_zero (ovr.clear),
        .step      (hi_step),
        .val_q     (hi_val)
    );

    // Output assembly: upper section above the toggle bit.
    always_comb begin
        cnt_q = CNT_W'({hi_val, lo_bit});
    end

endmodule

// File: rtl/dsdc_counter_chk.sv
// Module: dsdc_counter_chk
// What: port-level properties of dsdc_counter, bound into every instance.
// Assumes: default parameters (3-bit upper section, five states).
module dsdc_counter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       step_lo,
    input logic       step_hi,
    input logic       chain_en,
    input logic       clr_a,
    input logic       clr_b,
    input logic       nine_a,
    input logic       nine_b,
    input logic [3:0] cnt_q
);

    logic clr_all;
    logic nine_all;

    // Pair decode used by the properties.
    always_comb begin
        clr_all  = clr_a & clr_b;
        nine_all = nine_a & nine_b;
    end

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> cnt_q == 4'd0);

    // R2
    lo_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_all && !nine_all && step_lo) |=> cnt_q[0] != $past(cnt_q[0]));

    // R3
    hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_all && !nine_all && !chain_en && !step_hi) |=> $stable(cnt_q[3:1]));

    // R4
    chain_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_all && !nine_all && chain_en && !(step_lo && cnt_q[0]))
        |=> $stable(cnt_q[3:1]));

    // R5
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_all && !nine_all) |=> cnt_q == 4'd0);

    // R7
    preset_nine_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nine_all |=> cnt_q == 4'd9);

    // R10
    range_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cnt_q[3:1] <= 3'd4);

endmodule

bind dsdc_counter dsdc_counter_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_lo  (step_lo),
    .step_hi  (step_hi),
    .chain_en (chain_en),
    .clr_a    (clr_a),
    .clr_b    (clr_b),
    .nine_a   (nine_a),
    .nine_b   (nine_b),
    .cnt_q    (cnt_q)
);

// File: tb/dsdc_counter_tb.sv
module dsdc_counter_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       step_lo, step_hi, chain_en;
    logic       clr_a, clr_b, nine_a, nine_b;
    logic [3:0] cnt_q;

    int n_run  = 0;
    int n_fail = 0;
    int m_lo   = 0;
    int m_hi   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dsdc_counter dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_lo  (step_lo),
        .step_hi  (step_hi),
        .chain_en (chain_en),
        .clr_a    (clr_a),
        .clr_b    (clr_b),
        .nine_a   (nine_a),
        .nine_b   (nine_b),
        .cnt_q    (cnt_q)
    );

    task automatic check(input string tag, input int got, input int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // One clock: update the behavioural model from the inputs held over
    // the edge, then compare the full count and its range just after it.
    task automatic tick(input string tag);
        bit carry;
        @(posedge clk);
        if (!rst_n) begin
            m_lo = 0; m_hi = 0;
        end else if (nine_a && nine_b) begin
            m_lo = 1; m_hi = 4;
        end else if (clr_a && clr_b) begin
            m_lo = 0; m_hi = 0;
        end else begin
            carry = chain_en ? (step_lo && m_lo == 1) : step_hi;
            if (step_lo) m_lo = 1 - m_lo;
            if (carry)   m_hi = (m_hi + 1) % 5;
        end
        #1;
        check(tag, int'(cnt_q), m_hi * 2 + m_lo);
        check("R10", int'(cnt_q <= 4'd9), 1);
    endtask

    task automatic drive(input logic lo, input logic hi, input logic ch,
                         input logic ca, input logic cb,
                         input logic na, input logic nb);
        step_lo = lo; step_hi = hi; chain_en = ch;
        clr_a = ca; clr_b = cb; nine_a = na; nine_b = nb;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        drive(1, 1, 0, 0, 0, 0, 0);
        for (int i = 0; i < 3; i++) tick("R1");
        check("R1", int'(cnt_q), 0);
        rst_n = 1'b1;

        // R2: toggle section alone, steady then gapped enable
        drive(1, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 5; i++) tick("R2");
        for (int i = 0; i < 8; i++) begin
            step_lo = logic'(i % 3 == 0);
            tick("R2");
        end

        // R3: five-state section alone, wrap and independence from step_lo
        drive(0, 1, 0, 0, 0, 0, 0);
        for (int i = 0; i < 7; i++) tick("R3");
        for (int i = 0; i < 10; i++) begin
            step_hi = logic'(i[0]);
            step_lo = logic'(i % 3 != 1);
            tick("R3");
        end

        // R6: one clear input alone has no effect
        drive(1, 1, 0, 1, 0, 0, 0);
        for (int i = 0; i < 3; i++) tick("R6");
        drive(1, 1, 0, 0, 1, 0, 0);
        for (int i = 0; i < 3; i++) tick("R6");

        // R5: full clear overrides stepping
        drive(1, 1, 0, 1, 1, 0, 0);
        tick("R5");
        check("R5", int'(cnt_q), 0);

        // R8: one preset input alone has no effect
        drive(1, 1, 0, 0, 0, 1, 0);
        for (int i = 0; i < 3; i++) tick("R8");
        drive(1, 1, 0, 0, 0, 0, 1);
        for (int i = 0; i < 3; i++) tick("R8");

        // R7: full preset loads nine
        drive(1, 1, 0, 0, 0, 1, 1);
        tick("R7");
        check("R7", int'(cnt_q), 9);

        // R9: both pairs active, preset wins
        drive(0, 0, 0, 1, 1, 0, 0);
        tick("R5");
        drive(1, 1, 0, 1, 1, 1, 1);
        tick("R9");
        check("R9", int'(cnt_q), 9);

        // R4: internal chain, BCD sequence, step_hi ignored
        drive(0, 0, 1, 1, 1, 0, 0);
        tick("R4");
        drive(1, 0, 1, 0, 0, 0, 0);
        for (int i = 1; i <= 23; i++) begin
            step_hi = logic'(i[0]);
            tick("R4");
            check("R4", int'(cnt_q), i % 10);
        end
        for (int i = 0; i < 30; i++) begin
            step_lo = logic'(i % 4 != 2);
            step_hi = logic'(i % 5 == 0);
            tick("R4");
        end
        // chained preset then one step wraps to zero
        drive(0, 0, 1, 0, 0, 1, 1);
        tick("R7");
        drive(1, 1, 1, 0, 0, 0, 0);
        tick("R4");
        check("R4", int'(cnt_q), 0);

        // R1: reset mid-run
        drive(1, 1, 1, 0, 0, 0, 0);
        for (int i = 0; i < 3; i++) tick("R4");
        rst_n = 1'b0;
        tick("R1");
        check("R1", int'(cnt_q), 0);
        rst_n = 1'b1;
        tick("R2");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule